// File: doc/BRIEF.md
# Open-Row DRAM Command Sequencer

This block takes single-word read and write requests and turns each one into the row-activate, column-access and precharge steps that a banked DRAM array needs. It drives a behavioural array with several banks. Each bank has a row of sense-amplifier storage. An activate copies a whole row into that storage. A column access reads or overwrites one word of it. A precharge writes the row back to the cells and closes the bank.

After a request completes, the sequencer leaves the row open. A later request to the same row of that bank needs only a column access. A request to a different row of an open bank first closes the old row and then opens the new one. Reads may cover several beats. These beats run on consecutive cycles and step through the columns of the open row. The step counts from activate to column, from column to data and from precharge to activate are fixed parameters, and counters enforce them. While a sequence runs, `req_ready` is low. Read words come back with a one-cycle valid pulse.

Top module: `dram_open_row_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `cmd_code` is 0 (no command) and `rd_valid` is 0.
- R2: A request to a bank with no open row issues an activate (`cmd_code`=1) in the cycle after acceptance. It issues the column access (`cmd_code`=2) exactly T_RCD cycles after the activate.
- R3: A request to the row already open in its bank issues only a column access, in the cycle after acceptance.
- R4: A request to a different row of an open bank issues a precharge (`cmd_code`=3) carrying the old row in the cycle after acceptance. An activate of the new row follows T_RP cycles later, and the column access follows T_RCD cycles after that.
- R5: `req_addr` is split as {row, bank, column}. The column is the low COL_W bits. The bank is the next BANK_W bits above it. The row is the top ROW_W bits. `cmd_bank`, `cmd_row` and `cmd_col` report these fields with each command.
- R6: Each read column access produces `rd_valid`=1 for one cycle, exactly T_CL cycles after that access. `rd_data` then holds the word most recently written to that location, or 0 if the location has never been written.
- R7: A read with `req_len`=n issues n+1 column accesses on consecutive cycles. The column rises by one each beat and wraps from COLS-1 to 0 within the same row.
- R8: A write issues exactly one column access whatever `req_len` holds. Its data stays readable after the row is closed and opened again.
- R9: `req_ready` stays low from acceptance until the sequence ends. It returns to 1 in the cycle after a write's column access, or in the cycle that a read's last word is valid.
- R10: Opening or closing a row in one bank leaves the open row of every other bank unchanged.
- R11: An activate is issued only to a closed bank. A precharge or column access is issued only to an open bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle; the request is taken on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+BANK_W+COL_W (8) | Word address {row, bank, column} |
| req_len | input | LEN_W (3) | Extra read beats; ignored for writes |
| req_wdata | input | DATA_W (16) | Write word |
| rd_valid | output | 1 | Read word present |
| rd_data | output | DATA_W (16) | Read word |
| cmd_code | output | 2 | 0 none, 1 activate, 2 column, 3 precharge |
| cmd_bank | output | BANK_W (2) | Bank of the current command |
| cmd_row | output | ROW_W (3) | Row opened, accessed or closed |
| cmd_col | output | COL_W (3) | Column of a column access |

## Verification
A wrong open-row record shows at the ports on the next request to that bank. The first command after acceptance is then the wrong one: an activate where a column access belongs, or a missing precharge. A broken write-back first shows when a row is closed and reopened, as a wrong word T_CL cycles after the column access. The bench keeps its own record of the open row per bank and its own memory image. It predicts every command, its spacing, every read word and the cycle in which ready returns. Random traffic over few rows forces frequent row misses.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
   typedef enum logic [1:0] {
      CMD_NOP = 2'd0,
      CMD_ACT = 2'd1,
      CMD_COL = 2'd2,
      CMD_PRE = 2'd3
   } dram_cmd_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE,
      ST_ACT,
      ST_COL,
      ST_WAIT
   } seq_state_e;
endpackage

// File: rtl/dram_bank_store.sv
module dram_bank_store
   import dram_seq_pkg::*;
#(
   parameter int BANKS  = 4,
   parameter int ROWS   = 8,
   parameter int COLS   = 8,
   parameter int DATA_W = 16,
   localparam int BANK_W = $clog2(BANKS),
   localparam int ROW_W  = $clog2(ROWS),
   localparam int COL_W  = $clog2(COLS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  dram_cmd_e         cmd,
   input  logic [BANK_W-1:0] bank,
   input  logic [ROW_W-1:0]  row,
   input  logic [COL_W-1:0]  col,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int CELLS = BANKS * ROWS * COLS;
   localparam int SENSE = BANKS * COLS;

   logic [DATA_W-1:0] cells [CELLS];
   logic [DATA_W-1:0] sense [SENSE];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < CELLS; i++) cells[i] <= '0;
         for (int i = 0; i < SENSE; i++) sense[i] <= '0;
      end else begin
         case (cmd)
            CMD_ACT: begin
               for (int c = 0; c < COLS; c++)
                  sense[int'(bank) * COLS + c] <=
                     cells[(int'(bank) * ROWS + int'(row)) * COLS + c];
            end
            CMD_PRE: begin
               for (int c = 0; c < COLS; c++)
                  cells[(int'(bank) * ROWS + int'(row)) * COLS + c] <=
                     sense[int'(bank) * COLS + c];
            end
            CMD_COL: begin
               if (wr) sense[int'(bank) * COLS + int'(col)] <= wdata;
            end
            default: ;
         endcase
      end
   end

   assign rdata = sense[int'(bank) * COLS + int'(col)];
endmodule

// File: rtl/dram_open_rows.sv
module dram_open_rows
   import dram_seq_pkg::*;
#(
   parameter int BANKS = 4,
   parameter int ROWS  = 8,
   localparam int BANK_W = $clog2(BANKS),
   localparam int ROW_W  = $clog2(ROWS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  dram_cmd_e         cmd,
   input  logic [BANK_W-1:0] cmd_bank,
   input  logic [ROW_W-1:0]  cmd_row,
   input  logic [BANK_W-1:0] look_bank,
   output logic              look_open,
   output logic [ROW_W-1:0]  look_row
);
   logic             is_open [BANKS];
   logic [ROW_W-1:0] open_row [BANKS];

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            is_open[b]  <= 1'b0;
            open_row[b] <= '0;
         end else if (cmd_bank == BANK_W'(b)) begin
            if (cmd == CMD_ACT) begin
               is_open[b]  <= 1'b1;
               open_row[b] <= cmd_row;
            end else if (cmd == CMD_PRE) begin
               is_open[b]  <= 1'b0;
            end
         end
      end
   end

   assign look_open = is_open[look_bank];
   assign look_row  = open_row[look_bank];

   // R11: activate only into a closed bank
   p_act_closed_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cmd == CMD_ACT |-> !is_open[cmd_bank]);
   // R11: precharge only closes an open bank, and names its row
   p_pre_open_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cmd == CMD_PRE |-> is_open[cmd_bank] && open_row[cmd_bank] == cmd_row);
   // R11: column access only to the open row
   p_col_open_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cmd == CMD_COL |-> is_open[cmd_bank] && open_row[cmd_bank] == cmd_row);
endmodule

// File: rtl/dram_rd_pipe.sv
module dram_rd_pipe #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data
);
   logic [DEPTH-1:0]  vld;
   logic [DATA_W-1:0] dat [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (!rst_n) vld[0] <= 1'b0;
            else        vld[0] <= in_valid;
            dat[0] <= in_data;
         end
      end else begin : g_body
         always_ff @(posedge clk) begin
            if (!rst_n) vld[i] <= 1'b0;
            else        vld[i] <= vld[i-1];
            dat[i] <= dat[i-1];
         end
      end
   end

   assign out_valid = vld[DEPTH-1];
   assign out_data  = dat[DEPTH-1];
endmodule

// File: rtl/dram_open_row_seq.sv
module dram_open_row_seq
   import dram_seq_pkg::*;
#(
   parameter int BANKS    = 4,
   parameter int ROWS     = 8,
   parameter int COLS     = 8,
   parameter int DATA_W   = 16,
   parameter int MAX_BEATS = 8,
   parameter int T_RCD    = 2,
   parameter int T_CL     = 2,
   parameter int T_RP     = 2,
   localparam int BANK_W = $clog2(BANKS),
   localparam int ROW_W  = $clog2(ROWS),
   localparam int COL_W  = $clog2(COLS),
   localparam int ADDR_W = ROW_W + BANK_W + COL_W,
   localparam int LEN_W  = $clog2(MAX_BEATS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [1:0]        cmd_code,
   output logic [BANK_W-1:0] cmd_bank,
   output logic [ROW_W-1:0]  cmd_row,
   output logic [COL_W-1:0]  cmd_col
);
   localparam int T_MAX = (T_RCD > T_CL) ? ((T_RCD > T_RP) ? T_RCD : T_RP)
                                         : ((T_CL > T_RP) ? T_CL : T_RP);
   localparam int CNT_W = $clog2(T_MAX + 1);

   initial begin
      assert (T_RCD >= 1 && T_CL >= 1 && T_RP >= 1)
         else $error("step counts must be at least one cycle");
      assert (BANKS == (1 << BANK_W) && ROWS == (1 << ROW_W) && COLS == (1 << COL_W))
         else $error("banks, rows and columns must be powers of two");
      assert (MAX_BEATS == (1 << LEN_W) && MAX_BEATS <= COLS)
         else $error("burst limit must be a power of two within a row");
   end

   // address split {row, bank, col}
   logic [COL_W-1:0]  a_col;
   logic [BANK_W-1:0] a_bank;
   logic [ROW_W-1:0]  a_row;
   assign a_col  = req_addr[COL_W-1:0];
   assign a_bank = req_addr[COL_W +: BANK_W];
   assign a_row  = req_addr[COL_W + BANK_W +: ROW_W];

   seq_state_e        st, st_after;
   logic [CNT_W-1:0]  cnt;
   logic              q_write;
   logic [BANK_W-1:0] q_bank;
   logic [ROW_W-1:0]  q_row;
   logic [COL_W-1:0]  q_col;
   logic [LEN_W-1:0]  q_left;
   logic [DATA_W-1:0] q_wdata;

   logic              look_open;
   logic [ROW_W-1:0]  look_row;
   logic [BANK_W-1:0] look_bank;
   dram_cmd_e         cmd;
   logic [ROW_W-1:0]  c_row;
   logic [DATA_W-1:0] arr_rdata;

   assign look_bank = (st == ST_IDLE) ? a_bank : q_bank;

   always_comb begin
      cmd   = CMD_NOP;
      c_row = q_row;
      case (st)
         ST_PRE: begin cmd = CMD_PRE; c_row = look_row; end
         ST_ACT: cmd = CMD_ACT;
         ST_COL: cmd = CMD_COL;
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         st_after <= ST_IDLE;
         cnt      <= '0;
         q_write  <= 1'b0;
         q_bank   <= '0;
         q_row    <= '0;
         q_col    <= '0;
         q_left   <= '0;
         q_wdata  <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (req_valid) begin
                  q_write <= req_write;
                  q_bank  <= a_bank;
                  q_row   <= a_row;
                  q_col   <= a_col;
                  q_left  <= req_write ? '0 : req_len;
                  q_wdata <= req_wdata;
                  if (!look_open)           st <= ST_ACT;
                  else if (look_row == a_row) st <= ST_COL;
                  else                      st <= ST_PRE;
               end
            end
            ST_PRE: begin
               if (T_RP == 1) st <= ST_ACT;
               else begin
                  cnt      <= CNT_W'(T_RP - 1);
                  st_after <= ST_ACT;
                  st       <= ST_WAIT;
               end
            end
            ST_ACT: begin
               if (T_RCD == 1) st <= ST_COL;
               else begin
                  cnt      <= CNT_W'(T_RCD - 1);
                  st_after <= ST_COL;
                  st       <= ST_WAIT;
               end
            end
            ST_COL: begin
               if (q_left != '0) begin
                  q_left <= q_left - 1'b1;
                  q_col  <= q_col + 1'b1;
               end else if (q_write || T_CL == 1) begin
                  st <= ST_IDLE;
               end else begin
                  cnt      <= CNT_W'(T_CL - 1);
                  st_after <= ST_IDLE;
                  st       <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (cnt == CNT_W'(1)) st <= st_after;
               else                  cnt <= cnt - 1'b1;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   dram_open_rows #(.BANKS(BANKS), .ROWS(ROWS)) u_rows (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd      (cmd),
      .cmd_bank (q_bank),
      .cmd_row  (c_row),
      .look_bank(look_bank),
      .look_open(look_open),
      .look_row (look_row)
   );

   dram_bank_store #(.BANKS(BANKS), .ROWS(ROWS), .COLS(COLS), .DATA_W(DATA_W)) u_store (
      .clk  (clk),
      .rst_n(rst_n),
      .cmd  (cmd),
      .bank (q_bank),
      .row  (c_row),
      .col  (q_col),
      .wr   (q_write),
      .wdata(q_wdata),
      .rdata(arr_rdata)
   );

   dram_rd_pipe #(.DATA_W(DATA_W), .DEPTH(T_CL)) u_pipe (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (cmd == CMD_COL && !q_write),
      .in_data  (arr_rdata),
      .out_valid(rd_valid),
      .out_data (rd_data)
   );

   assign req_ready = (st == ST_IDLE);
   assign cmd_code  = cmd;
   assign cmd_bank  = q_bank;
   assign cmd_row   = c_row;
   assign cmd_col   = q_col;

   // R7: burst beats run back to back on rising columns
   p_burst_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_COL && q_left != '0) |=>
         (cmd == CMD_COL && q_col == $past(q_col) + 1'b1 && q_bank == $past(q_bank)));
   // R9: an accepted request drops ready on the next cycle
   p_ready_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && req_valid) |=> !req_ready);
   // R8: a write access is never followed by a second column beat
   p_write_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_COL && q_write) |=> cmd != CMD_COL);
endmodule

// File: tb/sim_dram_open_row_seq.sv
module sim_dram_open_row_seq;
   localparam int CLK_PERIOD = 10;
   localparam int BANKS = 4, ROWS = 8, COLS = 8, DW = 16, MB = 8;
   localparam int T_RCD = 2, T_CL = 2, T_RP = 2;
   localparam int BW = 2, RW = 3, CW = 3, LW = 3;

   logic clk = 0, rst_n = 0;
   logic req_valid = 0, req_write = 0;
   logic [RW+BW+CW-1:0] req_addr = '0;
   logic [LW-1:0] req_len = '0;
   logic [DW-1:0] req_wdata = '0;
   logic req_ready, rd_valid;
   logic [DW-1:0] rd_data;
   logic [1:0] cmd_code;
   logic [BW-1:0] cmd_bank;
   logic [RW-1:0] cmd_row;
   logic [CW-1:0] cmd_col;

   dram_open_row_seq #(.BANKS(BANKS), .ROWS(ROWS), .COLS(COLS), .DATA_W(DW),
      .MAX_BEATS(MB), .T_RCD(T_RCD), .T_CL(T_CL), .T_RP(T_RP)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
      .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
      .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col));

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct {
      int    code;
      int    bank;
      int    row;
      int    col;
      int    gap;
      bit    rd;
      string tag;
   } exp_cmd_t;

   exp_cmd_t  q_cmd [$];
   int        q_dat [$];
   string     q_dtag [$];
   int        q_due [$];
   int        n_cmp = 0, n_bad = 0;
   int        cyc = 0, last_cmd_cyc = 0;
   bit        finished = 0;

   int  m_mem [BANKS][ROWS][COLS];
   bit  m_open [BANKS];
   int  m_row [BANKS];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // monitor: compares commands, spacing and read words against the queues
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (cmd_code != 2'd0) begin
            check(req_ready == 1'b0, "R9 ready low during command", int'(req_ready), 0);
            if (q_cmd.size() == 0) begin
               check(1'b0, "R11 unexpected command", int'(cmd_code), 0);
            end else begin
               exp_cmd_t e;
               e = q_cmd.pop_front();
               check(int'(cmd_code) == e.code, {e.tag, " command code"}, int'(cmd_code), e.code);
               check(int'(cmd_bank) == e.bank, "R5 command bank", int'(cmd_bank), e.bank);
               check(int'(cmd_row) == e.row, {e.tag, " command row"}, int'(cmd_row), e.row);
               if (e.code == 2)
                  check(int'(cmd_col) == e.col, {e.tag, " column"}, int'(cmd_col), e.col);
               check(cyc - last_cmd_cyc == e.gap, {e.tag, " command spacing"},
                     cyc - last_cmd_cyc, e.gap);
               if (e.code == 2 && e.rd) q_due.push_back(cyc + T_CL);
            end
            last_cmd_cyc = cyc;
         end
         if (rd_valid) begin
            if (q_dat.size() == 0 || q_due.size() == 0) begin
               check(1'b0, "R6 unexpected read data", int'(rd_data), 0);
            end else begin
               int d, due;
               string t;
               d = q_dat.pop_front();
               t = q_dtag.pop_front();
               due = q_due.pop_front();
               check(int'(rd_data) == d, {t, " read word"}, int'(rd_data), d);
               check(cyc == due, "R6 read latency", cyc, due);
            end
         end
      end
   end

   function automatic exp_cmd_t mk(int code, int bank, int row, int col, int gap, bit rd, string tag);
      exp_cmd_t e;
      e.code = code; e.bank = bank; e.row = row; e.col = col;
      e.gap = gap; e.rd = rd; e.tag = tag;
      return e;
   endfunction

   task automatic do_req(input bit wr, input int bank, input int row, input int col,
                         input int len, input int wdata, input string tag);
      int delta, acc, beats;
      delta = 0;
      beats = wr ? 1 : len + 1;
      if (!m_open[bank]) begin
         q_cmd.push_back(mk(1, bank, row, 0, 1, 0, "R2"));
         q_cmd.push_back(mk(2, bank, row, col, T_RCD, !wr, {tag, "/R2"}));
         delta = 1 + T_RCD;
      end else if (m_row[bank] == row) begin
         q_cmd.push_back(mk(2, bank, row, col, 1, !wr, {tag, "/R3"}));
         delta = 1;
      end else begin
         q_cmd.push_back(mk(3, bank, m_row[bank], 0, 1, 0, "R4"));
         q_cmd.push_back(mk(1, bank, row, 0, T_RP, 0, "R4"));
         q_cmd.push_back(mk(2, bank, row, col, T_RCD, !wr, {tag, "/R4"}));
         delta = 1 + T_RP + T_RCD;
      end
      m_open[bank] = 1;
      m_row[bank]  = row;
      for (int k = 1; k < beats; k++) begin
         q_cmd.push_back(mk(2, bank, row, (col + k) % COLS, 1, 1, "R7"));
         delta++;
      end
      if (wr) begin
         m_mem[bank][row][col] = wdata & 16'hFFFF;
         delta += 1;
      end else begin
         for (int k = 0; k < beats; k++) begin
            q_dat.push_back(m_mem[bank][row][(col + k) % COLS]);
            q_dtag.push_back(tag);
         end
         delta += T_CL;
      end
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1;
      req_write = wr;
      req_addr  = {RW'(row), BW'(bank), CW'(col)};
      req_len   = LW'(len);
      req_wdata = DW'(wdata);
      acc = cyc;
      last_cmd_cyc = cyc;
      @(negedge clk);
      req_valid = 0;
      while (!req_ready) @(negedge clk);
      check(cyc - acc == delta, "R9 ready return cycle", cyc - acc, delta);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      int seed;
      for (int b = 0; b < BANKS; b++) begin
         m_open[b] = 0; m_row[b] = 0;
         for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) m_mem[b][r][c] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
      check(cmd_code == 2'd0, "R1 no command after reset", int'(cmd_code), 0);
      check(rd_valid == 1'b0, "R1 no read data after reset", int'(rd_valid), 0);

      do_req(1, 0, 1, 2, 0, 16'hA5A5, "R2");          // closed bank
      do_req(0, 0, 1, 2, 0, 0, "R3");                 // hit
      do_req(1, 0, 1, 7, 0, 16'h0707, "R8");
      do_req(1, 0, 1, 0, 0, 16'h1000, "R8");
      do_req(0, 0, 1, 6, 3, 0, "R7");                 // wrap 6,7,0,1
      do_req(1, 0, 1, 4, 3, 16'h4444, "R8");          // length ignored on write
      do_req(0, 0, 1, 4, 1, 0, "R8");
      do_req(1, 1, 5, 3, 0, 16'hBEEF, "R5");          // other bank
      do_req(0, 0, 1, 0, 0, 0, "R10");                // bank 0 still open
      do_req(0, 0, 2, 0, 0, 0, "R4");                 // miss, never written
      do_req(0, 0, 1, 2, 0, 0, "R8");                 // reopen: written-back word
      do_req(0, 1, 5, 3, 0, 0, "R10");
      do_req(0, 3, 7, 7, 7, 0, "R6");

      seed = 32'h1234_5678;
      for (int i = 0; i < 60; i++) begin
         seed = seed ^ (seed << 13);
         seed = seed ^ (seed >>> 17);
         seed = seed ^ (seed << 5);
         do_req(seed[0], int'(seed[5:4]), int'(seed[8:7]) & 3, int'(seed[12:10]),
                int'(seed[15:13]), int'(seed[31:16]), "R6");
      end

      repeat (T_CL + 4) @(negedge clk);
      check(q_cmd.size() == 0, "R11 commands left unissued", q_cmd.size(), 0);
      check(q_dat.size() == 0, "R6 read words left unreturned", q_dat.size(), 0);
      finish_run();
   end
endmodule